// File: doc/BRIEF.md
# Bus-Shared General-Purpose Port Controller

An eight-pin general-purpose I/O port whose pins can be handed over to an external data bus. Software programs it through four byte-wide registers on a simple CPU register bus: a pin direction register, an output data register, a read-only register that returns the sampled pin levels, and a pull-up enable register. The block drives a per-pin output enable, a per-pin output value and a per-pin pull-up request to the pad logic. It also raises a flag that tells the pads whether the pins currently belong to the external data bus.

Ownership depends on the operating mode and the bus-width select. In modes 4, 5 and 6 with the 16-bit bus selected, the data bus owns the pins and the port's direction settings have no effect. With the 8-bit bus, and always in mode 7, the direction register controls the pins. The direction register is write-only, and a read of it returns a fixed filler value.

Four reset and low-power conditions behave differently. Power-on reset clears all state, and so does hardware standby. Manual reset and software standby keep every register and block writes while they are asserted.

Top module: `gpio_busport`

## Requirements
- R1: While power-on reset (`por_n` low) is asserted, and after its release, the direction, data and pull-up registers read as 0x00 where readable, and `pin_oe`, `pin_out`, `pin_pu` and `rdata` are 0x00.
- R2: A write to address 0xFE3D loads the direction register on the clock edge that samples `wr_en`. Bit value 1 makes that pin an output. `pin_oe` shows the new value one clock later, while the pins are not owned by the data bus.
- R3: A read of address 0xFE3D always returns 0xFF, whatever the direction register holds.
- R4: Address 0xFF0D is a read/write data register. `pin_out` equals its contents one clock after the write, while the pins are not owned by the bus.
- R5: Address 0xFE44 is a read/write pull-up register. For each pin, `pin_pu` is 1 only when its pull-up bit is 1, its direction bit is 0, and the bus does not own the pins. `pin_pu` and `pin_oe` are never both 1 for the same pin.
- R6: A read of address 0xFFBD returns `pin_in` after a two-flop synchronizer. A read sampled on the first edge after a pin change still returns the old level. A write to 0xFFBD changes no register.
- R7: `bus_owned` is 1 exactly when `mode` is 4, 5 or 6 and `bus16` is 1. While it is 1, `pin_oe`, `pin_out` and `pin_pu` are 0x00 from the next clock on. The direction register still accepts writes and keeps them, and they take effect once ownership ends.
- R8: In mode 7, and in modes outside 4 to 6, the direction register controls `pin_oe` whatever the value of `bus16`.
- R9: While `hw_stby` is 1, the direction, data and pull-up registers clear to 0x00 and writes are ignored. The values stay 0x00 after release.
- R10: While `man_rst` or `sw_stby` is 1, writes are ignored and all registers keep their contents. `pin_oe` keeps its value.
- R11: A read of any other address returns 0x00, and a write to any other address changes no register.
- R12: `rdata` is updated on the edge that samples `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset; registers are kept, writes are blocked |
| hw_stby | input | 1 | Hardware standby; registers are cleared |
| sw_stby | input | 1 | Software standby; registers are kept, writes are blocked |
| mode | input | 3 | Operating mode number |
| bus16 | input | 1 | 1 selects the 16-bit external bus |
| addr | input | 16 | Register address, lower 16 bits |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up request |
| bus_owned | output | 1 | 1 when the external data bus owns the pins |

## Verification
Some properties are checked on every cycle. No pin ever has both a pull-up request and an output enable. A held register stays stable under manual reset or software standby, and hardware standby clears the registers. Reads of the direction address or of an unmapped address return their fixed values, and the pad outputs stay quiet while the bus owns the pins. Other behaviour only the bench scenarios can show. These cases are the one-cycle lag from a write to `pin_oe`, the stale value of a read taken one edge after a pin change, the mode 4 and mode 6 limits of the ownership range, and direction bits written during ownership taking effect once ownership ends.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W_DEF = 8;
    localparam int ADDR_W_DEF = 16;
    localparam int MODE_W_DEF = 3;

    localparam logic [15:0] DIR_ADDR_DEF  = 16'hFE3D;
    localparam logic [15:0] DATA_ADDR_DEF = 16'hFF0D;
    localparam logic [15:0] PIN_ADDR_DEF  = 16'hFFBD;
    localparam logic [15:0] PU_ADDR_DEF   = 16'hFE44;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_DATA = 3'd2,
        SEL_PIN  = 3'd3,
        SEL_PU   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int              W         = PORT_W_DEF,
    parameter int              AW        = ADDR_W_DEF,
    parameter logic [AW-1:0]   DIR_ADDR  = DIR_ADDR_DEF,
    parameter logic [AW-1:0]   DATA_ADDR = DATA_ADDR_DEF,
    parameter logic [AW-1:0]   PIN_ADDR  = PIN_ADDR_DEF,
    parameter logic [AW-1:0]   PU_ADDR   = PU_ADDR_DEF
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic          man_rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  ddr,
    output logic [W-1:0]  dr,
    output logic [W-1:0]  pcr,
    output logic [W-1:0]  rdata
);
    localparam logic [W-1:0] UNDEF_READ = '1;

    typedef struct packed {
        logic [W-1:0] ddr;
        logic [W-1:0] dr;
        logic [W-1:0] pcr;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;
    logic     wr_ok;

    always_comb begin
        if      (addr == DIR_ADDR)  sel = SEL_DIR;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else if (addr == PIN_ADDR)  sel = SEL_PIN;
        else if (addr == PU_ADDR)   sel = SEL_PU;
        else                        sel = SEL_NONE;
    end

    assign wr_ok = wr_en && !hw_stby && !sw_stby && !man_rst;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (sel)
                SEL_DIR:  st_d.ddr = wdata;
                SEL_DATA: st_d.dr  = wdata;
                SEL_PU:   st_d.pcr = wdata;
                default:  ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_DIR:  st_d.rdata = UNDEF_READ;
                SEL_DATA: st_d.rdata = st_q.dr;
                SEL_PIN:  st_d.rdata = pin_sync;
                SEL_PU:   st_d.rdata = st_q.pcr;
                default:  st_d.rdata = '0;
            endcase
        end
        if (hw_stby) begin
            st_d.ddr = '0;
            st_d.dr  = '0;
            st_d.pcr = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ddr   = st_q.ddr;
    assign dr    = st_q.dr;
    assign pcr   = st_q.pcr;
    assign rdata = st_q.rdata;

    assert_hw_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (ddr == '0 && dr == '0 && pcr == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        ((sw_stby || man_rst) && !hw_stby) |=> ($stable(ddr) && $stable(dr) && $stable(pcr)));

    assert_dir_undef_R3: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && addr == DIR_ADDR) |=> rdata == UNDEF_READ);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && sel == SEL_NONE) |=> rdata == '0);

    assert_pin_ro_R6: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && addr == PIN_ADDR && !hw_stby) |=> ($stable(ddr) && $stable(dr) && $stable(pcr)));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!por_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/gpio_port_pinctl.sv
module gpio_port_pinctl #(
    parameter int W       = 8,
    parameter int MODE_W  = 3,
    parameter int BUS_LO  = 4,
    parameter int BUS_HI  = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus16,
    input  logic [W-1:0]      ddr,
    input  logic [W-1:0]      dr,
    input  logic [W-1:0]      pcr,
    output logic              owned,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_pu
);
    localparam logic [MODE_W-1:0] MODE_LO = BUS_LO[MODE_W-1:0];
    localparam logic [MODE_W-1:0] MODE_HI = BUS_HI[MODE_W-1:0];

    typedef struct packed {
        logic [W-1:0] oe;
        logic [W-1:0] out;
        logic [W-1:0] pu;
    } pins_t;

    pins_t        pn_d, pn_q;
    logic [W-1:0] oe_c, out_c, pu_c;

    assign owned = bus16 && (mode >= MODE_LO) && (mode <= MODE_HI);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign oe_c[i]  = !owned && ddr[i];
        assign out_c[i] = !owned && dr[i];
        assign pu_c[i]  = !owned && !ddr[i] && pcr[i];
    end

    always_comb begin
        pn_d     = pn_q;
        pn_d.oe  = oe_c;
        pn_d.out = out_c;
        pn_d.pu  = pu_c;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pn_q <= '0;
        else        pn_q <= pn_d;
    end

    assign pin_oe  = pn_q.oe;
    assign pin_out = pn_q.out;
    assign pin_pu  = pn_q.pu;

    assert_pu_input_R5: assert property (@(posedge clk) disable iff (!por_n)
        (pin_pu & pin_oe) == '0);

    assert_owned_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
        (owned && $past(owned)) |-> (pin_oe == '0 && pin_out == '0 && pin_pu == '0));
endmodule

// File: rtl/gpio_busport.sv
module gpio_busport
    import gpio_port_pkg::*;
#(
    parameter int              PORT_W    = PORT_W_DEF,
    parameter int              ADDR_W    = ADDR_W_DEF,
    parameter int              MODE_W    = MODE_W_DEF,
    parameter int              SYNC_N    = 2,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = DIR_ADDR_DEF,
    parameter logic [ADDR_W-1:0] DATA_ADDR = DATA_ADDR_DEF,
    parameter logic [ADDR_W-1:0] PIN_ADDR  = PIN_ADDR_DEF,
    parameter logic [ADDR_W-1:0] PU_ADDR   = PU_ADDR_DEF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus16,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_pu,
    output logic              bus_owned
);
    logic [PORT_W-1:0] pin_sync, ddr, dr, pcr;

    gpio_port_sync #(.W(PORT_W), .STAGES(SYNC_N)) sync_i (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_port_regs #(
        .W(PORT_W), .AW(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR),
        .PIN_ADDR(PIN_ADDR), .PU_ADDR(PU_ADDR)
    ) regs_i (
        .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .man_rst(man_rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .pin_sync(pin_sync), .ddr(ddr), .dr(dr), .pcr(pcr),
        .rdata(rdata)
    );

    gpio_port_pinctl #(.W(PORT_W), .MODE_W(MODE_W)) pinctl_i (
        .clk(clk), .por_n(por_n), .mode(mode), .bus16(bus16), .ddr(ddr),
        .dr(dr), .pcr(pcr), .owned(bus_owned), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pu(pin_pu)
    );
endmodule

// File: tb/gpio_busport_tb_top.sv
module gpio_busport_tb_top;
    localparam logic [15:0] A_DIR  = 16'hFE3D;
    localparam logic [15:0] A_DATA = 16'hFF0D;
    localparam logic [15:0] A_PIN  = 16'hFFBD;
    localparam logic [15:0] A_PU   = 16'hFE44;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic        bus16 = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0, pin_in = '0;
    logic [7:0]  rdata, pin_oe, pin_out, pin_pu;
    logic        bus_owned;

    int checks = 0, failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    gpio_busport dut_i (
        .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .mode(mode), .bus16(bus16), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .bus_owned(bus_owned)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Driver: all inputs change on the falling edge.
    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: a read sampled at an edge is compared at the following falling edge.
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R12 actual=%02h expected=none (unexpected read data)", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1 pin_oe in reset", pin_oe, 8'h00);
        check("R1 pin_pu in reset", pin_pu, 8'h00);
        check("R1 rdata in reset", rdata, 8'h00);
        por_n = 1'b1;
        idle(2);
        check("R1 pin_out after reset", pin_out, 8'h00);
        rd(A_DATA, 8'h00, "R1 data reg reset");
        rd(A_PU, 8'h00, "R1 pull-up reg reset");
        rd(A_DIR, 8'hFF, "R3 direction read after reset");

        // R2: direction, one-cycle lag to pin_oe
        wr(A_DIR, 8'h0F);
        check("R2 pin_oe not yet updated", pin_oe, 8'h00);
        idle(1);
        check("R2 pin_oe follows direction", pin_oe, 8'h0F);
        rd(A_DIR, 8'hFF, "R3 direction read with 0F stored");

        // R4: data register
        wr(A_DATA, 8'hA5);
        idle(1);
        check("R4 pin_out follows data", pin_out, 8'hA5);
        rd(A_DATA, 8'hA5, "R4 data readback");

        // R5: pull-ups only on input pins
        wr(A_PU, 8'hFF);
        idle(1);
        check("R5 pull-ups on inputs only", pin_pu, 8'hF0);
        rd(A_PU, 8'hFF, "R5 pull-up readback");

        // R6: synchronized pin read
        pin_in = 8'h3C;
        idle(3);
        rd(A_PIN, 8'h3C, "R6 pin read settled");
        pin_in = 8'hC3;
        rd(A_PIN, 8'h3C, "R6 pin read one edge after change is stale");
        idle(2);
        rd(A_PIN, 8'hC3, "R6 pin read after sync");
        wr(A_PIN, 8'h55);
        rd(A_DATA, 8'hA5, "R6 write to pin address leaves data");
        rd(A_PU, 8'hFF, "R6 write to pin address leaves pull-up");

        // R7: bus ownership
        mode = 3'd5; bus16 = 1'b1; #1;
        check("R7 bus_owned mode5 16-bit", {7'd0, bus_owned}, 8'h01);
        idle(2);
        check("R7 pin_oe quiet when owned", pin_oe, 8'h00);
        check("R7 pin_out quiet when owned", pin_out, 8'h00);
        check("R7 pin_pu quiet when owned", pin_pu, 8'h00);
        wr(A_DIR, 8'hFF);
        bus16 = 1'b0; #1;
        check("R7 bus_owned mode5 8-bit", {7'd0, bus_owned}, 8'h00);
        idle(2);
        check("R7 direction kept through ownership", pin_oe, 8'hFF);
        check("R7 pin_pu off for outputs", pin_pu, 8'h00);
        mode = 3'd4; bus16 = 1'b1; #1;
        check("R7 bus_owned mode4", {7'd0, bus_owned}, 8'h01);
        mode = 3'd6; #1;
        check("R7 bus_owned mode6", {7'd0, bus_owned}, 8'h01);

        // R8: mode 7 and modes outside the range
        mode = 3'd7; #1;
        check("R8 mode7 not owned", {7'd0, bus_owned}, 8'h00);
        idle(2);
        check("R8 mode7 direction controls", pin_oe, 8'hFF);
        mode = 3'd3; #1;
        check("R8 mode3 not owned", {7'd0, bus_owned}, 8'h00);
        mode = 3'd7; bus16 = 1'b0;

        // R10: software standby and manual reset keep state
        @(negedge clk); sw_stby = 1'b1;
        wr(A_DATA, 8'h00);
        rd(A_DATA, 8'hA5, "R10 data kept in software standby");
        @(negedge clk); sw_stby = 1'b0; man_rst = 1'b1;
        wr(A_DIR, 8'h01);
        @(negedge clk); man_rst = 1'b0;
        idle(2);
        check("R10 direction kept through manual reset", pin_oe, 8'hFF);
        rd(A_PU, 8'hFF, "R10 pull-up kept through manual reset");

        // R9: hardware standby clears
        @(negedge clk); hw_stby = 1'b1;
        wr(A_DATA, 8'h77);
        @(negedge clk); hw_stby = 1'b0;
        idle(2);
        check("R9 pin_oe cleared by hardware standby", pin_oe, 8'h00);
        rd(A_DATA, 8'h00, "R9 data cleared, write ignored");
        rd(A_PU, 8'h00, "R9 pull-up cleared");

        // R11: unmapped addresses
        wr(16'h1234, 8'h99);
        rd(16'h1234, 8'h00, "R11 unmapped read");
        rd(A_DATA, 8'h00, "R11 unmapped write ignored");

        // R12: rdata holds without a read strobe
        idle(3);
        check("R12 rdata holds", rdata, 8'h00);

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R12 actual=%0d expected=0 pending reads", exp_q.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule